// File: doc/BRIEF.md
# Inverting-Output Static Word Memory

This block is a small static memory of sixteen 4-bit words with separate input and output data buses. Two active-low strobes set its mode. A chip-select strobe enables the device. A write strobe selects between storing and reading. The read path returns the bitwise complement of the stored word. The output bus is released to high impedance whenever the device is not in read mode.

In silicon the write is strobed asynchronously. Here the system clock stands in for that strobe: a write is captured on a rising edge while both strobes are sampled low. Reads are combinational from the address into the registered array. Inside the block, the three-state condition is carried as a data word plus an enable flag. A single tri-state assignment turns these into a pin bus at the top boundary. Reset clears every word to zero. The strobes are plain control pins with no valid/ready handshake, so there is no back-pressure: a write is accepted in the cycle it is presented, and a read is valid as soon as the address settles.

Top module: `inv_sram16x4`

## Requirements
- R1: The array holds 16 independent 4-bit words, selected by a 4-bit address. Writing one address leaves every other address unchanged.
- R2: On a rising clock edge with `cs_n`=0 and `we_n`=0, the word on `din` is stored at `addr`.
- R3: While `cs_n`=0 and `we_n`=1 (read mode), `rd_oe`=1 and `rd_data` equals the bitwise complement of the word stored at `addr`. This follows the address combinationally, without waiting for a clock edge.
- R4: While `cs_n`=1 (standby), `rd_oe`=0 whatever the level of `we_n`.
- R5: While `cs_n`=0 and `we_n`=0 (write mode), `rd_oe`=0.
- R6: When `cs_n` and `we_n` both rise in the same cycle at the end of a write, `rd_oe` stays 0 and never pulses high.
- R7: A clock edge with `cs_n`=1, or with `we_n`=1, changes no stored word.
- R8: Stored words keep their value indefinitely with no refresh. With a fixed address and no write, `rd_data` is stable.
- R9: An active-low `rst_n` clears all words to zero, so a read right after reset returns 4'hF.
- R10: When `rd_oe`=1, `q_pin` carries `rd_data`; when `rd_oe`=0, `q_pin` is high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that stands in for the write strobe |
| rst_n | input | 1 | Asynchronous active-low reset; clears the array |
| addr | input | 4 | Word address |
| din | input | 4 | Write data |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable |
| rd_data | output | 4 | Complement of the addressed word |
| rd_oe | output | 1 | High when the output bus is driven (read mode) |
| q_pin | output | 4 | Three-state output bus |

## Verification
Some properties hold on every cycle, and the assertions check them continuously. These are the mode-to-enable mapping in standby, read and write, and the absence of an enable pulse when both strobes rise together. They also cover the rule that a write followed by a read of the same address returns the complement of the written word, and that a read output stays steady when the address is held and nothing is written. Other behaviour is only visible through the bench's scenarios. That includes the cleared state after reset, the independence of all sixteen words under two full sweeps with different patterns, and the rejection of write attempts while deselected or in read mode. It also includes retention over a long idle stretch and agreement between the pin bus and the data word.

// File: rtl/inv_sram_pkg.sv
package inv_sram_pkg;
  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_READ    = 2'd1,
    MODE_WRITE   = 2'd2
  } sram_mode_t;
endpackage

// File: rtl/inv_sram_mode_dec.sv
module inv_sram_mode_dec
  import inv_sram_pkg::*;
(
  input  logic cs_n,
  input  logic we_n,
  output logic wr_en,
  output logic rd_en
);
  sram_mode_t mode;

  always_comb begin
    if (cs_n)      mode = MODE_STANDBY;
    else if (we_n) mode = MODE_READ;
    else           mode = MODE_WRITE;
  end

  assign wr_en = (mode == MODE_WRITE);
  assign rd_en = (mode == MODE_READ);
endmodule

// File: rtl/inv_sram_array.sv
module inv_sram_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [DEPTH-1:0][DATA_W-1:0]  words
);
  logic [DEPTH-1:0] word_sel;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign word_sel[g] = wr_en && (wr_addr == ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           words[g] <= '0;
      else if (word_sel[g]) words[g] <= wr_data;
    end
  end
endmodule

// File: rtl/inv_sram_rdpath.sv
module inv_sram_rdpath #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic [DEPTH-1:0][DATA_W-1:0] words,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [DATA_W-1:0]            rd_inv
);
  assign rd_inv = ~words[rd_addr];
endmodule

// File: rtl/inv_sram16x4.sv
module inv_sram16x4 #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              cs_n,
  input  logic              we_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe,
  output wire  [DATA_W-1:0] q_pin
);
  localparam int DEPTH = 1 << ADDR_W;

  logic                         wr_en;
  logic                         rd_en;
  logic [DEPTH-1:0][DATA_W-1:0] words;

  inv_sram_mode_dec u_dec (
    .cs_n  (cs_n),
    .we_n  (we_n),
    .wr_en (wr_en),
    .rd_en (rd_en)
  );

  inv_sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (addr),
    .wr_data (din),
    .words   (words)
  );

  inv_sram_rdpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .words   (words),
    .rd_addr (addr),
    .rd_inv  (rd_data)
  );

  assign rd_oe = rd_en;
  assign q_pin = rd_oe ? rd_data : {DATA_W{1'bz}};
endmodule

// File: rtl/inv_sram_chk.sv
module inv_sram_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] din,
  input logic              cs_n,
  input logic              we_n,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_oe
);
  AST_READ_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && we_n) |-> rd_oe); // R3

  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !rd_oe); // R4

  AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n) |-> !rd_oe); // R5

  AST_NO_END_GLITCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cs_n && !we_n) && cs_n && we_n) |-> !rd_oe); // R6

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n) |=>
      (!(!cs_n && we_n && addr == $past(addr)) || rd_data == ~$past(din))); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n || we_n) && $stable(addr) && !cs_n && we_n) |-> $stable(rd_data)); // R8
endmodule

bind inv_sram16x4 inv_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .din     (din),
  .cs_n    (cs_n),
  .we_n    (we_n),
  .rd_data (rd_data),
  .rd_oe   (rd_oe)
);

// File: tb/inv_sram16x4_test.sv
`timescale 1ns/1ps
module inv_sram16x4_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic [3:0] din = '0;
  logic       cs_n = 1'b1;
  logic       we_n = 1'b1;
  logic [3:0] rd_data;
  logic       rd_oe;
  wire  [3:0] q_pin;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  inv_sram16x4 uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .cs_n(cs_n), .we_n(we_n), .rd_data(rd_data), .rd_oe(rd_oe), .q_pin(q_pin)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic c, input logic w, input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    cs_n = c; we_n = w; addr = a; din = d;
    #2;
  endtask

  task automatic do_write(input logic [3:0] a, input logic [3:0] d);
    drive(1'b0, 1'b0, a, d);
    chk("R5 oe in write", {3'b0, rd_oe}, 4'h0);
  endtask

  task automatic do_read(input string req, input logic [3:0] a, input logic [3:0] exp);
    drive(1'b0, 1'b1, a, ~a);
    chk("R3 oe in read", {3'b0, rd_oe}, 4'h1);
    chk(req, rd_data, exp);
    chk("R10 pin follows data", q_pin, exp);
  endtask

  function automatic logic [3:0] pat_a(input int i);
    return 4'((i * 5 + 3) % 16);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R4 oe during reset", {3'b0, rd_oe}, 4'h0);
    rst_n = 1'b1;

    // R9: cleared array reads all ones
    for (int i = 0; i < 16; i++) do_read("R9 reset contents", 4'(i), 4'hF);

    // R4: standby with both write-enable levels
    drive(1'b1, 1'b1, 4'h2, 4'h0);
    chk("R4 standby we high", {3'b0, rd_oe}, 4'h0);
    drive(1'b1, 1'b0, 4'h2, 4'h0);
    chk("R4 standby we low", {3'b0, rd_oe}, 4'h0);

    // R1 R2 R3: distinct words everywhere
    for (int i = 0; i < 16; i++) do_write(4'(i), pat_a(i));
    for (int i = 0; i < 16; i++) do_read("R1 R2 sweep A", 4'(i), ~pat_a(i));

    // R6: both strobes rise together after a write
    do_write(4'h6, 4'h9);
    drive(1'b1, 1'b1, 4'h6, 4'h0);
    chk("R6 end of write", {3'b0, rd_oe}, 4'h0);
    #6;
    chk("R6 end of write late", {3'b0, rd_oe}, 4'h0);
    do_read("R2 written by end-of-write cycle", 4'h6, 4'h6);

    // R7: write attempts while deselected, and din changes in read mode
    drive(1'b1, 1'b0, 4'h6, 4'h3);
    drive(1'b1, 1'b0, 4'hA, 4'h0);
    drive(1'b0, 1'b1, 4'hA, 4'h5);
    do_read("R7 deselected write ignored", 4'h6, 4'h6);
    do_read("R7 read-mode din ignored", 4'hA, ~pat_a(10));

    // R1: second sweep with a different pattern
    for (int i = 0; i < 16; i++) do_write(4'(i), 4'(i) ^ 4'hC);
    for (int i = 0; i < 16; i++) do_read("R1 sweep B", 4'(i), ~(4'(i) ^ 4'hC));

    // R8: retention over a long idle stretch
    drive(1'b1, 1'b1, 4'h0, 4'h0);
    repeat (1000) @(negedge clk);
    for (int i = 0; i < 16; i++) do_read("R8 retention", 4'(i), ~(4'(i) ^ 4'hC));

    // R9: reset again clears the array
    drive(1'b1, 1'b1, 4'h0, 4'h0);
    rst_n = 1'b0;
    #4;
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) do_read("R9 second reset", 4'(i), 4'hF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule